// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder/Decoder

This block sits between a UART and an infrared transceiver. On the transmit side it watches the UART's serial output bit. For every zero bit, the start bit included, it emits one short light pulse. A one bit leaves the emitter dark. On the receive side it watches the transceiver's pulse output and rebuilds an NRZ line for the UART: each detected pulse becomes one full bit time of logic low, delayed by half a bit.

All timing is counted in ticks of a 16x baud-rate clock enable (`tick16`), supplied by the UART's baud generator. One bit period spans sixteen ticks. The raw IR input is asynchronous. It passes through a two-flop synchronizer, and its rising edge is caught at system-clock resolution and held until the next tick. This lets very short pulses (about 1.6 µs) be seen even when they fall between ticks. A pulse that arrives before the current window has run its course re-aligns the timing, so the decoder tolerates jitter.

When `en` is low the block is transparent. Both paths copy their input to their output through one register stage, and the internal timing state is cleared.

Top module: `ir_sir_codec`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `ir_txd_o` is 0 (emitter dark) and `uart_rxd_o` is 1 (line idle).
- R2: With `en` high, a bit period begins on the tick at which `uart_txd_i` is first seen with a new value; that tick is phase 0, and phases count 0 to 15 and wrap for repeated equal bits. For a zero bit, `ir_txd_o` becomes 1 at the register update of phase 7 and stays 1 for exactly 3 ticks (phases 7, 8, 9). Each further consecutive zero bit gives its own pulse 16 ticks later.
- R3: With `en` high, a tick that samples `uart_txd_i` = 1 leaves `ir_txd_o` at 0 after that tick, so a one bit produces no pulse.
- R4: `ir_rxd_i` is active high (1 = light). It passes through two synchronizer flops, and a rising edge of the synchronized signal is detected at the system clock. A pulse lasting a single clock cycle is therefore detected even when no tick occurs during it. It is held pending and consumed by the next tick, which is called the trigger tick.
- R5: `uart_rxd_o` goes to 0 at the 8th tick after a trigger tick and stays 0 for exactly 16 ticks, then returns to 1 (given no further pulses).
- R6: Pulses whose trigger ticks are 16 apart keep `uart_rxd_o` continuously low across the bits, with a single falling edge.
- R7: A trigger arriving while an earlier trigger is still waiting out its 8-tick delay restarts that delay and drops the earlier one. A window start arriving while a window is running restarts the 16-tick window.
- R8: With `en` low, `ir_txd_o` equals `uart_txd_i` and `uart_rxd_o` equals `ir_rxd_i`, each as sampled at the previous clock edge. Pending pulses, delays, windows and bit-phase tracking are cleared, so after re-enabling, the first zero bit is timed from its own transition.
- R9: With `en` high, both outputs change only at clock edges where `tick16` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | 1 = IR encode/decode, 0 = transparent pass-through |
| tick16 | input | 1 | Clock enable at 16x the baud rate |
| uart_txd_i | input | 1 | Serial transmit bit from the UART |
| ir_rxd_i | input | 1 | Raw pulse input from the IR receiver, active high |
| ir_txd_o | output | 1 | Pulse output to the IR emitter, active high |
| uart_rxd_o | output | 1 | Reconstructed NRZ receive bit to the UART |

## Verification
Two functions can meet on a single tick. One is the expiry of a pending 8-tick delay, which opens a low window. The other is a new trigger, which starts a fresh delay. The bench provokes this with pulse pairs spaced exactly 8 ticks apart and also with pairs 3, 15 and 17 ticks apart. A tick-indexed behavioural model judges the result on every clock, while a transmit frame runs through the encoder at the same time. The count of falling edges on the receive line checks that the first window opens and the second delay still lands.

// File: rtl/ir_sir_pkg.sv
package ir_sir_pkg;

  // Bits needed to hold values 0..n
  function automatic int cw(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ir_sir_sync.sv
module ir_sir_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];

endmodule

// File: rtl/ir_sir_tx.sv
module ir_sir_tx #(
  parameter int BIT_TICKS = 16,
  parameter int TX_OFFSET = 7,
  parameter int TX_WIDTH  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic txd,
  output logic ir_tx
);

  localparam int PW = ir_sir_pkg::cw(BIT_TICKS - 1);
  localparam logic [PW-1:0] LAST   = PW'(BIT_TICKS - 1);
  localparam logic [PW-1:0] WIN_LO = PW'(TX_OFFSET);
  localparam logic [PW-1:0] WIN_HI = PW'(TX_OFFSET + TX_WIDTH - 1);

  logic          txd_q;
  logic [PW-1:0] phase;
  logic [PW-1:0] cur;
  logic          in_win;

  // A transition marks phase 0 of a new bit period
  always_comb begin
    cur    = (txd ^ txd_q) ? '0 : phase;
    in_win = (cur >= WIN_LO) && (cur <= WIN_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_q <= 1'b1;
      phase <= '0;
      ir_tx <= 1'b0;
    end else if (!en) begin
      txd_q <= 1'b1;
      phase <= '0;
      ir_tx <= txd;
    end else if (tick) begin
      txd_q <= txd;
      phase <= (cur == LAST) ? '0 : cur + 1'b1;
      ir_tx <= ~txd & in_win;
    end
  end

endmodule

// File: rtl/ir_sir_rx.sv
module ir_sir_rx #(
  parameter int BIT_TICKS = 16,
  parameter int RX_DELAY  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic ir_s,
  input  logic ir_raw,
  output logic rxd
);

  localparam int DW = ir_sir_pkg::cw(RX_DELAY - 1);
  localparam int WW = ir_sir_pkg::cw(BIT_TICKS - 1);
  localparam logic [DW-1:0] D_INIT = DW'(RX_DELAY - 1);
  localparam logic [WW-1:0] W_INIT = WW'(BIT_TICKS - 1);

  logic          ir_q;
  logic          rise;
  logic          pend;
  logic          dly_on;
  logic [DW-1:0] dcnt;
  logic          win_on;
  logic [WW-1:0] wcnt;
  logic          fire;

  always_comb begin
    rise = ir_s & ~ir_q;
    fire = dly_on && (dcnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q   <= 1'b0;
      pend   <= 1'b0;
      dly_on <= 1'b0;
      dcnt   <= '0;
      win_on <= 1'b0;
      wcnt   <= '0;
      rxd    <= 1'b1;
    end else begin
      ir_q <= ir_s;
      if (!en) begin
        pend   <= 1'b0;
        dly_on <= 1'b0;
        dcnt   <= '0;
        win_on <= 1'b0;
        wcnt   <= '0;
        rxd    <= ir_raw;
      end else if (tick) begin
        pend <= 1'b0;
        // delay stage: a new trigger always restarts it
        if (pend | rise) begin
          dly_on <= 1'b1;
          dcnt   <= D_INIT;
        end else if (fire) begin
          dly_on <= 1'b0;
        end else if (dly_on) begin
          dcnt <= dcnt - 1'b1;
        end
        // window stage: a delay expiry (re)starts it
        if (fire) begin
          win_on <= 1'b1;
          wcnt   <= W_INIT;
        end else if (win_on) begin
          if (wcnt == '0) win_on <= 1'b0;
          else            wcnt   <= wcnt - 1'b1;
        end
        rxd <= ~(fire | (win_on & (wcnt != '0)));
      end else begin
        pend <= pend | rise;
      end
    end
  end

endmodule

// File: rtl/ir_sir_codec.sv
module ir_sir_codec #(
  parameter int BIT_TICKS   = 16,
  parameter int TX_OFFSET   = 7,
  parameter int TX_WIDTH    = 3,
  parameter int RX_DELAY    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick16,
  input  logic uart_txd_i,
  input  logic ir_rxd_i,
  output logic ir_txd_o,
  output logic uart_rxd_o
);

  logic ir_sync;

  ir_sir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ir_rxd_i),
    .q   (ir_sync)
  );

  ir_sir_tx #(
    .BIT_TICKS (BIT_TICKS),
    .TX_OFFSET (TX_OFFSET),
    .TX_WIDTH  (TX_WIDTH)
  ) u_tx (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .tick  (tick16),
    .txd   (uart_txd_i),
    .ir_tx (ir_txd_o)
  );

  ir_sir_rx #(
    .BIT_TICKS (BIT_TICKS),
    .RX_DELAY  (RX_DELAY)
  ) u_rx (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .tick   (tick16),
    .ir_s   (ir_sync),
    .ir_raw (ir_rxd_i),
    .rxd    (uart_rxd_o)
  );

endmodule

// File: rtl/ir_sir_codec_chk.sv
module ir_sir_codec_chk #(
  parameter int TX_WIDTH = 3
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic tick16,
  input logic uart_txd_i,
  input logic ir_rxd_i,
  input logic ir_txd_o,
  input logic uart_rxd_o
);

  localparam int HW = ir_sir_pkg::cw(TX_WIDTH + 1);
  localparam logic [HW-1:0] HMAX = HW'(TX_WIDTH);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)  hi_cnt <= '0;
    else if (tick16) hi_cnt <= ir_txd_o ? ((hi_cnt == HMAX) ? hi_cnt + 1'b1 : hi_cnt + 1'b1) : '0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ir_txd_o == 1'b0 && uart_rxd_o == 1'b1));

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= HMAX);

  // R3
  one_bit_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick16 && uart_txd_i) |=> !ir_txd_o);

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (ir_txd_o == $past(uart_txd_i) && uart_rxd_o == $past(ir_rxd_i)));

  // R9
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !tick16) |=> ($stable(ir_txd_o) && $stable(uart_rxd_o)));

endmodule

bind ir_sir_codec ir_sir_codec_chk #(.TX_WIDTH(TX_WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .tick16     (tick16),
  .uart_txd_i (uart_txd_i),
  .ir_rxd_i   (ir_rxd_i),
  .ir_txd_o   (ir_txd_o),
  .uart_rxd_o (uart_rxd_o)
);

// File: tb/ir_sir_codec_bench.sv
module ir_sir_codec_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic tick16 = 1'b0;
  logic uart_txd_i = 1'b1;
  logic ir_rxd_i = 1'b0;
  logic ir_txd_o;
  logic uart_rxd_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  string tag_tx = "R1";
  string tag_rx = "R1";

  ir_sir_codec u_ir_sir_codec (
    .clk(clk), .rst(rst), .en(en), .tick16(tick16),
    .uart_txd_i(uart_txd_i), .ir_rxd_i(ir_rxd_i),
    .ir_txd_o(ir_txd_o), .uart_rxd_o(uart_rxd_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int d;
    d = 0;
    forever begin
      @(negedge clk);
      d = (d + 1) % TICK_DIV;
      tick16 = (d == 0);
    end
  end

  // ---------------- reference model (tick-indexed) ----------------
  logic exp_tx = 1'b0;
  logic exp_rx = 1'b1;
  logic h1 = 0, h2 = 0, h3 = 0;
  logic m_pend = 0;
  logic prev_txd = 1;
  int   tix = 0;
  int   bstart = 0;
  int   pend_trig = -1;
  int   last_fire = -100;
  bit   free_edge = 0;

  always @(posedge clk) begin
    logic r, trg;
    int ph;
    r = h2 & ~h3;
    free_edge = en && !tick16 && !rst;
    if (rst) begin
      exp_tx = 0; exp_rx = 1; m_pend = 0; prev_txd = 1;
      tix = 0; bstart = 0; pend_trig = -1; last_fire = -100;
    end else if (!en) begin
      exp_tx = uart_txd_i; exp_rx = ir_rxd_i; m_pend = 0; prev_txd = 1;
      tix = 0; bstart = 0; pend_trig = -1; last_fire = -100;
    end else if (tick16) begin
      if (uart_txd_i != prev_txd) bstart = tix;
      prev_txd = uart_txd_i;
      ph = (tix - bstart) % 16;
      exp_tx = !uart_txd_i && ph >= 7 && ph <= 9;
      trg = m_pend | r;
      m_pend = 0;
      if (pend_trig >= 0 && tix == pend_trig + 8) begin
        last_fire = tix;
        pend_trig = -1;
      end
      if (trg) pend_trig = tix;
      exp_rx = (last_fire >= 0 && tix - last_fire < 16) ? 1'b0 : 1'b1;
      tix++;
    end else begin
      m_pend = m_pend | r;
    end
    if (rst) begin h1 = 0; h2 = 0; h3 = 0; end
    else begin h3 = h2; h2 = h1; h1 = ir_rxd_i; end
  end

  // ---------------- checking ----------------
  task automatic chk(input logic act, input logic exp, input string tag, input string name);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic cnt_chk(input int act, input int exp, input string tag, input string name);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
    end
  endtask

  int   tx_pulses = 0;
  int   rx_falls = 0;
  logic last_tx = 1'b0;
  logic last_rx = 1'b1;

  always @(negedge clk) begin
    if (!done) begin
      chk(ir_txd_o, exp_tx, tag_tx, "ir_txd_o");
      chk(uart_rxd_o, exp_rx, tag_rx, "uart_rxd_o");
      if (free_edge) begin
        chk(ir_txd_o, last_tx, "R9", "ir_txd_o off-tick");
        chk(uart_rxd_o, last_rx, "R9", "uart_rxd_o off-tick");
      end
      if (ir_txd_o === 1'b1 && last_tx === 1'b0) tx_pulses++;
      if (uart_rxd_o === 1'b0 && last_rx === 1'b1) rx_falls++;
      last_tx = ir_txd_o;
      last_rx = uart_rxd_o;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!tick16);
    end
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b);
    logic [9:0] bits;
    bits = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      uart_txd_i = bits[i];
      wait_ticks(16);
    end
  endtask

  task automatic ir_pulse(input int n);
    ir_rxd_i = 1'b1;
    repeat (n) @(negedge clk);
    ir_rxd_i = 1'b0;
  endtask

  task automatic pulse_pair(input int gap);
    int f0;
    f0 = rx_falls;
    fork ir_pulse(2); join_none
    wait_ticks(gap);
    fork ir_pulse(2); join_none
    wait_ticks(44);
    cnt_chk(rx_falls - f0, 1, "R7", $sformatf("falls for gap %0d", gap));
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int p0, f0;
    repeat (4) @(negedge clk);
    rst = 1'b0;                       // R1 checked on every reset cycle
    wait_ticks(3);
    tag_tx = "R2"; tag_rx = "R5";

    // R2: frame with isolated and consecutive zero bits
    p0 = tx_pulses;
    send_frame(8'hA5);
    cnt_chk(tx_pulses - p0, 5, "R2", "pulses for 0xA5 frame");
    p0 = tx_pulses;
    send_frame(8'h00);
    cnt_chk(tx_pulses - p0, 9, "R2", "pulses for 0x00 frame");

    // R3: all ones give only the start-bit pulse
    tag_tx = "R3";
    p0 = tx_pulses;
    send_frame(8'hFF);
    wait_ticks(20);
    cnt_chk(tx_pulses - p0, 1, "R3", "pulses for 0xFF frame");
    tag_tx = "R2";

    // R4: single-clock pulse
    tag_rx = "R4";
    f0 = rx_falls;
    ir_pulse(1);
    wait_ticks(30);
    cnt_chk(rx_falls - f0, 1, "R4", "falls for 1-clock pulse");

    // R5: ordinary pulse
    tag_rx = "R5";
    f0 = rx_falls;
    ir_pulse(4);
    wait_ticks(30);
    cnt_chk(rx_falls - f0, 1, "R5", "falls for single pulse");

    // R6: pulses 16 ticks apart
    tag_rx = "R6";
    f0 = rx_falls;
    for (int k = 0; k < 4; k++) begin
      fork ir_pulse(2); join_none
      wait_ticks(16);
    end
    wait_ticks(30);
    cnt_chk(rx_falls - f0, 1, "R6", "falls for 4 back-to-back pulses");

    // R7: re-alignment, incl. trigger on the delay-expiry tick
    tag_rx = "R7";
    pulse_pair(3);
    pulse_pair(8);
    pulse_pair(15);
    f0 = rx_falls;
    fork ir_pulse(2); join_none
    wait_ticks(17);
    fork ir_pulse(2); join_none
    wait_ticks(44);
    cnt_chk(rx_falls - f0, 2, "R7", "falls for late jittered pulse");

    // encoder and decoder together
    tag_rx = "R6";
    fork
      send_frame(8'h3C);
      begin
        for (int k = 0; k < 6; k++) begin
          fork ir_pulse(3); join_none
          wait_ticks(16);
        end
      end
    join
    wait_ticks(30);

    // R8: transparent mode
    tag_tx = "R8"; tag_rx = "R8";
    en = 1'b0;
    for (int k = 0; k < 24; k++) begin
      uart_txd_i = k[0] ^ k[2];
      ir_rxd_i   = k[1];
      @(negedge clk);
    end
    uart_txd_i = 1'b1; ir_rxd_i = 1'b0;
    @(negedge clk);
    en = 1'b1;
    wait_ticks(5);
    p0 = tx_pulses;
    send_frame(8'h0F);
    wait_ticks(10);
    cnt_chk(tx_pulses - p0, 5, "R8", "pulses after re-enable");
    cnt_chk(int'(uart_rxd_o), 1, "R8", "receive line idle after re-enable");

    finish_run();
  end

endmodule